// File: doc/BRIEF.md
# Bitonic Sorting Network

The block sorts a group of 2^LOG_WORDS unsigned words, each WORD_W bits wide, into ascending order. Word i of a group occupies bits `[i*WORD_W +: WORD_W]` of the flat data vector. Word 0 of the output is the smallest value. The network uses only compare-and-swap cells, and its wiring never depends on the data.

The cells are arranged as a bitonic merge network with LOG_WORDS*(LOG_WORDS+1)/2 ranks. For each block size 2^k the merge works as follows:

- The first rank compares each element of the lower half with its mirror in the upper half. This is equivalent to reversing the upper half to form a bitonic sequence and then running a half-cleaner over it.
- The ranks that follow are plain half-cleaners on blocks of halving size.

When `PIPELINED` is set, a register follows every rank. Data and valid then move through the ranks together, one group per cycle. When `PIPELINED` is clear, the block is purely combinational.

Both sides use a valid/ready stream. A group transfers on a clock edge where valid and ready are both high.

In the pipelined build, the whole pipeline advances when the output slot is empty or the downstream side is ready. The block therefore asserts `in_ready` exactly in that case. A stalled output holds its data until it is taken. In the combinational build, `in_ready` mirrors `out_ready` and `out_valid` mirrors `in_valid`.

Top module: `bitonic_sorter`

## Requirements
- R1: Whenever `out_valid` is high, the output words are non-decreasing from word 0 (bits `[WORD_W-1:0]`) to the last word.
- R2: Every group accepted at the input appears at the output, in acceptance order, as a permutation of its input words.
- R3: With `PIPELINED`=1 and `out_ready` held high, a group accepted on a clock edge appears with `out_valid` high after exactly LOG_WORDS*(LOG_WORDS+1)/2 clock edges, counting the accepting edge.
- R4: With `PIPELINED`=1, `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output data and valid hold on the next edge.
- R5: With `PIPELINED`=1, a synchronous active-high `rst` clears `out_valid`, and `in_ready` is high afterwards.
- R6: With `PIPELINED`=0, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the output is the sorted input in the same cycle.
- R7: Groups containing repeated values sort correctly, and repeated values keep their multiplicity.
- R8: All 2^(2^LOG_WORDS) groups whose words are each 0 or 1 sort correctly.
- R9: Groups containing the extreme values 0 and 2^WORD_W-1 sort correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input group is offered |
| in_ready | output | 1 | The block can take an input group |
| in_data | input | 2^LOG_WORDS*WORD_W | Unsorted group, word i at `[i*WORD_W +: WORD_W]` |
| out_valid | output | 1 | A sorted group is presented |
| out_ready | input | 1 | The downstream side takes the group |
| out_data | output | 2^LOG_WORDS*WORD_W | Sorted group, word 0 the smallest |

## Verification
The hardest situation to reach is a stall while the pipeline holds several groups in flight with bubbles between them. Every rank must then freeze together without dropping or duplicating a group. The stimulus streams groups with `in_valid` and `out_ready` toggled pseudo-randomly. A scoreboard matches every emerging group against the sorted copy of its accepted input. A cycle-by-cycle check confirms that a stalled output holds its value.

Sortedness of every 0/1 group is checked exhaustively.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

  function automatic int rank_total(input int n);
    return n * (n + 1) / 2;
  endfunction

  // Merge level (log2 of block size) served by rank r.
  function automatic int level_of(input int r, input int n);
    int base;
    base = 0;
    for (int k = 1; k <= n; k++) begin
      if (r < base + k) return k;
      base += k;
    end
    return n;
  endfunction

  // log2 of the compare span of rank r; equals level_of(r) on the mirror rank.
  function automatic int span_of(input int r, input int n);
    int base;
    base = 0;
    for (int k = 1; k <= n; k++) begin
      if (r < base + k) return k - (r - base);
      base += k;
    end
    return 1;
  endfunction

endpackage

// File: rtl/bsn_cas.sv
module bsn_cas #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] hi
);
  logic swap;
  assign swap = a > b;
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;
endmodule

// File: rtl/bsn_rank.sv
module bsn_rank #(
  parameter int LOG_WORDS = 3,
  parameter int WORD_W    = 8,
  parameter int LEVEL     = 1,
  parameter int SPAN      = 1
) (
  input  logic [(1<<LOG_WORDS)*WORD_W-1:0] d_i,
  output logic [(1<<LOG_WORDS)*WORD_W-1:0] d_o
);
  localparam int PAIRS = (1 << LOG_WORDS) / 2;
  localparam int DIST  = 1 << (SPAN - 1);
  localparam bit MIRROR = (SPAN == LEVEL);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int BASE = (p / DIST) * (2 * DIST);
    localparam int OFS  = p % DIST;
    localparam int LO   = BASE + OFS;
    localparam int HI   = MIRROR ? (BASE + 2 * DIST - 1 - OFS) : (LO + DIST);
    bsn_cas #(.WORD_W(WORD_W)) u_cas (
      .a  (d_i[LO*WORD_W +: WORD_W]),
      .b  (d_i[HI*WORD_W +: WORD_W]),
      .lo (d_o[LO*WORD_W +: WORD_W]),
      .hi (d_o[HI*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter #(
  parameter int LOG_WORDS = 3,
  parameter int WORD_W    = 8,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [(1<<LOG_WORDS)*WORD_W-1:0]    in_data,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [(1<<LOG_WORDS)*WORD_W-1:0]    out_data
);
  import bsn_pkg::*;

  localparam int WORDS = 1 << LOG_WORDS;
  localparam int FLAT  = WORDS * WORD_W;
  localparam int RANKS = rank_total(LOG_WORDS);

  logic adv;
  assign adv = !out_valid || out_ready;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic [FLAT-1:0] d_in, nx, q;
    logic            v_in, qv;

    if (r == 0) begin : g_head
      assign d_in = in_data;
      assign v_in = in_valid;
    end else begin : g_link
      assign d_in = g_rank[r-1].q;
      assign v_in = g_rank[r-1].qv;
    end

    bsn_rank #(
      .LOG_WORDS (LOG_WORDS),
      .WORD_W    (WORD_W),
      .LEVEL     (level_of(r, LOG_WORDS)),
      .SPAN      (span_of(r, LOG_WORDS))
    ) u_rank (
      .d_i (d_in),
      .d_o (nx)
    );

    if (PIPELINED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)      qv <= 1'b0;
        else if (adv) qv <= v_in;
      end
      always_ff @(posedge clk) begin
        if (adv) q <= nx;
      end
    end else begin : g_wire
      assign q  = nx;
      assign qv = v_in;
    end
  end

  assign out_data  = g_rank[RANKS-1].q;
  assign out_valid = g_rank[RANKS-1].qv;

  if (PIPELINED) begin : g_rdy_pipe
    assign in_ready = adv;

    // R4: a stalled output keeps its group
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R4: an empty output slot always accepts
    p_empty_ready_r4: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

    // R5: reset empties the output
    p_reset_r5: assert property (@(posedge clk)
      rst |=> !out_valid);
  end else begin : g_rdy_comb
    assign in_ready = out_ready;
  end

  // R1: presented groups are ascending
  for (genvar w = 1; w < WORDS; w++) begin : g_ord
    p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_data[w*WORD_W +: WORD_W] >= out_data[(w-1)*WORD_W +: WORD_W]);
  end

endmodule

// File: tb/tb_bitonic_sorter.sv
`timescale 1ns/1ps
module tb_bitonic_sorter;
  localparam int LW    = 3;
  localparam int M     = 8;
  localparam int W     = 1 << LW;
  localparam int FLAT  = W * M;
  localparam int RANKS = LW * (LW + 1) / 2;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic            in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [FLAT-1:0] in_data = '0, out_data;
  logic            c_in_valid = 0, c_in_ready, c_out_valid, c_out_ready = 0;
  logic [FLAT-1:0] c_in_data = '0, c_out_data;

  bitonic_sorter #(.LOG_WORDS(LW), .WORD_W(M), .PIPELINED(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  bitonic_sorter #(.LOG_WORDS(LW), .WORD_W(M), .PIPELINED(1'b0)) dut_c (
    .clk(clk), .rst(rst), .in_valid(c_in_valid), .in_ready(c_in_ready), .in_data(c_in_data),
    .out_valid(c_out_valid), .out_ready(c_out_ready), .out_data(c_out_data));

  int checks = 0, fails = 0;
  logic [FLAT-1:0] expq [0:1023];
  int wr = 0, rd = 0;
  logic            stalled = 0;
  logic [FLAT-1:0] held;

  function automatic logic [FLAT-1:0] ref_sort(input logic [FLAT-1:0] v);
    logic [M-1:0] a [W];
    logic [M-1:0] t;
    logic [FLAT-1:0] o;
    for (int i = 0; i < W; i++) a[i] = v[i*M +: M];
    for (int i = 1; i < W; i++)
      for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
        t = a[j]; a[j] = a[j-1]; a[j-1] = t;
      end
    for (int i = 0; i < W; i++) o[i*M +: M] = a[i];
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [FLAT-1:0] act,
                       input logic [FLAT-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard and handshake monitor for the pipelined instance
  always @(posedge clk) begin
    if (!rst) begin
      check(in_ready == (!out_valid || out_ready), "R4 in_ready rule",
            FLAT'(in_ready), FLAT'(!out_valid || out_ready));
      if (stalled)
        check(out_valid && out_data == held, "R4 stall hold", out_data, held);
      stalled = out_valid && !out_ready;
      held    = out_data;
      if (out_valid && out_ready) begin
        // R1 ascending and R2 permutation of the accepted group
        check(rd < wr && out_data == expq[rd[9:0]], "R2 sorted permutation",
              out_data, expq[rd[9:0]]);
        rd++;
      end
      if (in_valid && in_ready) begin
        expq[wr[9:0]] = ref_sort(in_data);
        wr++;
      end
    end else begin
      stalled = 0;
    end
  end

  task automatic push(input logic [FLAT-1:0] v);
    @(negedge clk);
    in_valid = 1; in_data = v;
    do @(posedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain(input string req);
    out_ready = 1;
    for (int i = 0; i < 4 * RANKS && rd != wr; i++) @(negedge clk);
    check(rd == wr, req, FLAT'(rd), FLAT'(wr));
  endtask

  task automatic t_reset;
    rst = 1; repeat (3) @(negedge clk);
    check(!out_valid, "R5 out_valid after reset", FLAT'(out_valid), '0);
    check(in_ready, "R5 in_ready after reset", FLAT'(in_ready), FLAT'(1));
    rst = 0;
  endtask

  task automatic t_latency;
    logic [FLAT-1:0] v;
    v = {8'd3, 8'd200, 8'd7, 8'd1, 8'd90, 8'd44, 8'd12, 8'd5};
    out_ready = 1;
    @(negedge clk); in_valid = 1; in_data = v;
    @(negedge clk); in_valid = 0;          // accepted on edge 1
    for (int e = 1; e < RANKS; e++) begin
      check(!out_valid, "R3 no early output", FLAT'(out_valid), '0);
      @(negedge clk);
    end
    check(out_valid, "R3 valid after rank count", FLAT'(out_valid), FLAT'(1));
    check(out_data == ref_sort(v), "R3 R1 latency data", out_data, ref_sort(v));
    drain("R3 drain");
  endtask

  task automatic t_zero_one;
    out_ready = 1;
    for (int p = 0; p < (1 << W); p++) begin
      logic [FLAT-1:0] v;
      for (int i = 0; i < W; i++) v[i*M +: M] = M'(p[i]);
      @(negedge clk); in_valid = 1; in_data = v;
    end
    @(negedge clk); in_valid = 0;
    drain("R8 all 0/1 groups emerged");
  endtask

  task automatic t_dup_extreme;
    push({8{8'd77}});                                                  // R7 all equal
    push({8'd9, 8'd4, 8'd9, 8'd4, 8'd9, 8'd4, 8'd9, 8'd4});            // R7 repeats
    push({8'd0, 8'd255, 8'd0, 8'd255, 8'd128, 8'd0, 8'd255, 8'd1});   // R9 extremes
    push({8'd255, 8'd254, 8'd253, 8'd2, 8'd1, 8'd0, 8'd255, 8'd0});   // R9 extremes
    drain("R7 R9 groups emerged");
  endtask

  task automatic t_backpressure;
    int sent;
    sent = 0;
    while (sent < 300) begin
      @(negedge clk);
      out_ready = ($urandom % 3) != 0;
      if (in_valid && in_ready) sent++;
      if (!in_valid || in_ready) begin
        in_valid = ($urandom % 4) != 0;
        in_data  = {$urandom, $urandom};
      end
    end
    @(negedge clk); in_valid = 0;
    drain("R4 R2 stream under stalls");
  endtask

  task automatic t_comb;
    logic [FLAT-1:0] v;
    for (int n = 0; n < 6; n++) begin
      v = (n == 0) ? {8{8'd255}} : {$urandom, $urandom};
      c_in_data = v; c_in_valid = n[0]; c_out_ready = n[1];
      #1;
      check(c_out_data == ref_sort(v), "R6 same-cycle sort", c_out_data, ref_sort(v));
      check(c_out_valid == c_in_valid, "R6 valid pass", FLAT'(c_out_valid), FLAT'(c_in_valid));
      check(c_in_ready == c_out_ready, "R6 ready pass", FLAT'(c_in_ready), FLAT'(c_out_ready));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_zero_one();
    t_dup_extreme();
    t_backpressure();
    t_comb();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule